// File: doc/BRIEF.md
# Segment Descriptor Fetch Unit

This block turns a 16-bit protected-mode segment selector into a decoded segment descriptor. On a request it splits the selector into its fields and picks the global or the local descriptor table. It then checks that the whole 8-byte entry fits within that table's limit. If it does, the block reads the two 32-bit descriptor words through a single request/acknowledge memory port.

The fetched words are decoded into base, expanded limit, type, privilege level, present flag, size and granularity bits, along with the gate fields. The block also decides whether the descriptor is valid for its type. When the caller asks for the accessed update, a present code or data descriptor gets its accessed flag set by a read-modify-write of the high word. A one-cycle completion pulse carries a status code. The decoded fields stay on the outputs until the next successful fetch.

Top module: `seg_desc_fetch`

## Requirements
- R1: On acceptance the selector is split as follows: `rpl` = selector[1:0], `tbl_local` = selector[2], and the byte offset of the entry is the selector with bits 2:0 cleared.
- R2: If selector[2] is 1 and `ldt_ok` is 0, the block completes with status 1 and makes no memory access.
- R3: If offset + 7 is greater than the selected table's limit, the block completes with status 2 and makes no memory access. The global table uses `gdt_base`/`gdt_limit`; the local table uses `ldt_base`/`ldt_limit`.
- R4: The low word is read from table base + offset, and then the high word from that address + 4, in that order.
- R5: Decoded fields of the high word: present is bit 15, DPL is bits 14:13, the code/data flag is bit 12, type is bits 11:8, default size is bit 22 and granularity is bit 23.
- R6: `d_base` = {high[31:24], high[7:0], low[31:16]}. The raw limit is {high[19:16], low[15:0]}. When granularity is 1, `d_limit` = raw << 12 with the low 12 bits set to one; otherwise it is the zero-extended raw limit.
- R7: Gate types 4, 6, 7, 12, 14 and 15 (code/data flag 0) are valid only when high[7:5] is 0. For gates, `g_sel` = low[31:16], `g_off` = {high[31:16], low[15:0]} and `g_cnt` = high[4:0].
- R8: Code/data descriptors are always valid. System types 1, 2, 3, 5, 9 and 11 are valid. System types 0, 8, 10 and 13 are invalid. An invalid descriptor completes with status 3.
- R9: With `mark_acc` set on a valid descriptor whose present bit is 0, the block completes with status 4 and makes no further memory access.
- R10: With `mark_acc` set on a present code/data descriptor, the block reads the high word again. If bit 8 of that word is 0, it writes the word back with bit 8 set; if bit 8 is already 1, no write takes place. System descriptors are never written.
- R11: `done` pulses for one cycle with `status` (0 ok, 1 no local table, 2 limit, 3 invalid, 4 not present). A request is accepted in any idle cycle, including the cycle in which `done` is high.
- R12: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a lookup (sampled when idle) |
| selector | input | 16 | Segment selector |
| mark_acc | input | 1 | Request the present check and the accessed-flag update |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 32 | Global table byte limit |
| ldt_ok | input | 1 | A valid local table is loaded |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 32 | Local table byte limit |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | 32 | Access byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes |
| mem_rdata | input | 32 | Read data, valid with ack |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Completion code |
| rpl | output | 2 | Requested privilege of the last selector |
| tbl_local | output | 1 | Last selector named the local table |
| d_present | output | 1 | Present flag |
| d_dpl | output | 2 | Descriptor privilege level |
| d_codedata | output | 1 | Code/data (1) or system (0) |
| d_type | output | 4 | Type field |
| d_dflt | output | 1 | Default size bit |
| d_gran | output | 1 | Granularity bit |
| d_base | output | 32 | Assembled base |
| d_limit | output | 32 | Expanded limit |
| d_valid | output | 1 | Descriptor valid for its type |
| g_sel | output | 16 | Gate target selector |
| g_off | output | 32 | Gate target offset |
| g_cnt | output | 5 | Gate parameter count |

## Verification
The completion of one lookup and the acceptance of the next can fall in the same cycle. To provoke this, the bench holds `req` high through a successful fetch and presents, in the completion cycle, a second selector that overruns the table limit. The check passes only if the second `done` appears in the very next cycle with status 2, the memory port stays idle, and the first lookup's decoded fields are left intact.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  localparam int WORD_W = 32;
  localparam int SEL_W  = 16;
  localparam int ACC_BIT = 8;
  localparam int PAGE_SH = 12;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_NO_LDT  = 3'd1,
    ST_LIMIT   = 3'd2,
    ST_INVALID = 3'd3,
    ST_NOT_PRS = 3'd4
  } status_e;

  typedef struct packed {
    logic        present;
    logic [1:0]  dpl;
    logic        codedata;
    logic [3:0]  typ;
    logic        dflt;
    logic        gran;
    logic [31:0] base;
    logic [31:0] limit;
    logic        valid;
    logic [15:0] gsel;
    logic [31:0] goff;
    logic [4:0]  gcnt;
  } desc_t;

  function automatic logic [31:0] seg_base(input logic [31:0] lo, input logic [31:0] hi);
    return {hi[31:24], hi[7:0], lo[31:16]};
  endfunction

  function automatic logic [31:0] seg_limit(input logic [31:0] lo, input logic [31:0] hi);
    logic [19:0] raw;
    raw = {hi[19:16], lo[15:0]};
    if (hi[23]) return {raw, {PAGE_SH{1'b1}}};
    return {12'd0, raw};
  endfunction

  function automatic logic is_gate(input logic [3:0] t);
    return (t == 4'd4) || (t == 4'd6) || (t == 4'd7) ||
           (t == 4'd12) || (t == 4'd14) || (t == 4'd15);
  endfunction

  function automatic logic sys_ok(input logic [3:0] t, input logic [31:0] hi);
    if (is_gate(t)) return hi[7:5] == 3'd0;
    return (t == 4'd1) || (t == 4'd2) || (t == 4'd3) ||
           (t == 4'd5) || (t == 4'd9) || (t == 4'd11);
  endfunction

  function automatic logic span_exceeds(input logic [15:0] off, input logic [31:0] lim);
    logic [32:0] last_byte;
    last_byte = {17'd0, off} + 33'd7;
    return last_byte > {1'b0, lim};
  endfunction

endpackage

// File: rtl/sdf_sel_check.sv
module sdf_sel_check
  import sdf_pkg::*;
(
  input  logic [SEL_W-1:0]  selector,
  input  logic [WORD_W-1:0] gdt_base,
  input  logic [WORD_W-1:0] gdt_limit,
  input  logic              ldt_ok,
  input  logic [WORD_W-1:0] ldt_base,
  input  logic [WORD_W-1:0] ldt_limit,
  output logic [WORD_W-1:0] desc_addr,
  output logic              no_ldt,
  output logic              lim_fail
);
  logic              use_local;
  logic [SEL_W-1:0]  offset;
  logic [WORD_W-1:0] tab_base;
  logic [WORD_W-1:0] tab_lim;

  always_comb begin
    use_local = selector[2];
    offset    = {selector[SEL_W-1:3], 3'b000};
    tab_base  = use_local ? ldt_base  : gdt_base;
    tab_lim   = use_local ? ldt_limit : gdt_limit;
    no_ldt    = use_local && !ldt_ok;
    lim_fail  = span_exceeds(offset, tab_lim);
    desc_addr = tab_base + {{(WORD_W-SEL_W){1'b0}}, offset};
  end
endmodule

// File: rtl/sdf_decode.sv
module sdf_decode
  import sdf_pkg::*;
(
  input  logic [WORD_W-1:0] lo,
  input  logic [WORD_W-1:0] hi,
  output desc_t             d
);
  always_comb begin
    d.present  = hi[15];
    d.dpl      = hi[14:13];
    d.codedata = hi[12];
    d.typ      = hi[11:8];
    d.dflt     = hi[22];
    d.gran     = hi[23];
    d.base     = seg_base(lo, hi);
    d.limit    = seg_limit(lo, hi);
    d.valid    = hi[12] ? 1'b1 : sys_ok(hi[11:8], hi);
    d.gsel     = lo[31:16];
    d.goff     = {hi[31:16], lo[15:0]};
    d.gcnt     = hi[4:0];
  end
endmodule

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
  import sdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [SEL_W-1:0]  selector,
  input  logic              mark_acc,
  input  logic              no_ldt,
  input  logic              lim_fail,
  input  logic [WORD_W-1:0] desc_addr,
  input  logic              dec_valid,
  input  logic              dec_present,
  input  logic              dec_codedata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] lo_q,
  output logic [WORD_W-1:0] hi_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              mark_q,
  output logic              done,
  output logic [2:0]        status,
  output logic              accept_ev,
  output logic              lo_ack_ev
);
  typedef enum logic [2:0] {
    C_IDLE, C_LO, C_HI, C_EVAL, C_ARD, C_AWR
  } cstate_e;

  cstate_e state;

  assign mem_req   = (state == C_LO) || (state == C_HI) ||
                     (state == C_ARD) || (state == C_AWR);
  assign mem_we    = (state == C_AWR);
  assign accept_ev = (state == C_IDLE) && req;
  assign lo_ack_ev = (state == C_LO) && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= C_IDLE;
      done      <= 1'b0;
      status    <= ST_OK;
      mem_addr  <= '0;
      mem_wdata <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      sel_q     <= '0;
      mark_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        C_IDLE: begin
          if (req) begin
            sel_q  <= selector;
            mark_q <= mark_acc;
            if (no_ldt) begin
              done   <= 1'b1;
              status <= ST_NO_LDT;
            end else if (lim_fail) begin
              done   <= 1'b1;
              status <= ST_LIMIT;
            end else begin
              mem_addr <= desc_addr;
              state    <= C_LO;
            end
          end
        end
        C_LO: begin
          if (mem_ack) begin
            lo_q     <= mem_rdata;
            mem_addr <= mem_addr + 32'd4;
            state    <= C_HI;
          end
        end
        C_HI: begin
          if (mem_ack) begin
            hi_q  <= mem_rdata;
            state <= C_EVAL;
          end
        end
        C_EVAL: begin
          if (!dec_valid) begin
            done <= 1'b1; status <= ST_INVALID; state <= C_IDLE;
          end else if (!mark_q) begin
            done <= 1'b1; status <= ST_OK; state <= C_IDLE;
          end else if (!dec_present) begin
            done <= 1'b1; status <= ST_NOT_PRS; state <= C_IDLE;
          end else if (!dec_codedata) begin
            done <= 1'b1; status <= ST_OK; state <= C_IDLE;
          end else begin
            state <= C_ARD;
          end
        end
        C_ARD: begin
          if (mem_ack) begin
            if (mem_rdata[ACC_BIT]) begin
              done <= 1'b1; status <= ST_OK; state <= C_IDLE;
            end else begin
              mem_wdata <= mem_rdata | (32'd1 << ACC_BIT);
              state     <= C_AWR;
            end
          end
        end
        C_AWR: begin
          if (mem_ack) begin
            done <= 1'b1; status <= ST_OK; state <= C_IDLE;
          end
        end
        default: state <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import sdf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [15:0] selector,
  input  logic        mark_acc,
  input  logic [31:0] gdt_base,
  input  logic [31:0] gdt_limit,
  input  logic        ldt_ok,
  input  logic [31:0] ldt_base,
  input  logic [31:0] ldt_limit,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic [2:0]  status,
  output logic [1:0]  rpl,
  output logic        tbl_local,
  output logic        d_present,
  output logic [1:0]  d_dpl,
  output logic        d_codedata,
  output logic [3:0]  d_type,
  output logic        d_dflt,
  output logic        d_gran,
  output logic [31:0] d_base,
  output logic [31:0] d_limit,
  output logic        d_valid,
  output logic [15:0] g_sel,
  output logic [31:0] g_off,
  output logic [4:0]  g_cnt
);
  logic [WORD_W-1:0] desc_addr;
  logic              no_ldt;
  logic              lim_fail;
  logic              sel_fault_ev;
  logic [WORD_W-1:0] lo_q;
  logic [WORD_W-1:0] hi_q;
  logic [SEL_W-1:0]  sel_q;
  logic              mark_q;
  logic              accept_ev;
  logic              lo_ack_ev;
  desc_t             dec;

  sdf_sel_check u_sel (
    .selector  (selector),
    .gdt_base  (gdt_base),
    .gdt_limit (gdt_limit),
    .ldt_ok    (ldt_ok),
    .ldt_base  (ldt_base),
    .ldt_limit (ldt_limit),
    .desc_addr (desc_addr),
    .no_ldt    (no_ldt),
    .lim_fail  (lim_fail)
  );

  assign sel_fault_ev = no_ldt || lim_fail;

  sdf_decode u_dec (
    .lo (lo_q),
    .hi (hi_q),
    .d  (dec)
  );

  sdf_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .selector     (selector),
    .mark_acc     (mark_acc),
    .no_ldt       (no_ldt),
    .lim_fail     (lim_fail),
    .desc_addr    (desc_addr),
    .dec_valid    (dec.valid),
    .dec_present  (dec.present),
    .dec_codedata (dec.codedata),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .lo_q         (lo_q),
    .hi_q         (hi_q),
    .sel_q        (sel_q),
    .mark_q       (mark_q),
    .done         (done),
    .status       (status),
    .accept_ev    (accept_ev),
    .lo_ack_ev    (lo_ack_ev)
  );

  assign rpl        = sel_q[1:0];
  assign tbl_local  = sel_q[2];
  assign d_present  = dec.present;
  assign d_dpl      = dec.dpl;
  assign d_codedata = dec.codedata;
  assign d_type     = dec.typ;
  assign d_dflt     = dec.dflt;
  assign d_gran     = dec.gran;
  assign d_base     = dec.base;
  assign d_limit    = dec.limit;
  assign d_valid    = dec.valid;
  assign g_sel      = dec.gsel;
  assign g_off      = dec.goff;
  assign g_cnt      = dec.gcnt;
endmodule

// File: rtl/sdf_chk.sv
module sdf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        done,
  input logic [2:0]  status,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        accept_ev,
  input logic        sel_fault_ev,
  input logic        lo_ack_ev,
  input logic        d_valid,
  input logic        d_present,
  input logic        d_codedata,
  input logic        mark_q
);
  AST_SEL_FAULT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev && sel_fault_ev |=> done && !mem_req); // R2
  AST_LIMIT_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 3'd2 |-> !mem_req); // R3
  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    lo_ack_ev |=> mem_req && !mem_we && mem_addr == $past(mem_addr) + 32'd4); // R4
  AST_INVALID_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 3'd3 |-> !d_valid); // R8
  AST_NOT_PRESENT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 3'd4 |-> !d_present); // R9
  AST_WRITE_ONLY_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[8] && d_codedata && d_present && mark_q); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !req |=> !done); // R11
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12
endmodule

bind seg_desc_fetch sdf_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req          (req),
  .done         (done),
  .status       (status),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .accept_ev    (accept_ev),
  .sel_fault_ev (sel_fault_ev),
  .lo_ack_ev    (lo_ack_ev),
  .d_valid      (d_valid),
  .d_present    (d_present),
  .d_codedata   (d_codedata),
  .mark_q       (mark_q)
);

// File: tb/sim_seg_desc_fetch.sv
module sim_seg_desc_fetch;
  localparam int PERIOD = 10;
  localparam logic [31:0] GBASE = 32'h40;
  localparam logic [31:0] GLIM  = 32'h3F;
  localparam logic [31:0] LBASE = 32'h80;
  localparam logic [31:0] LLIM  = 32'h1F;

  typedef struct packed {
    logic [15:0] sel;
    logic        lok;
    logic        mark;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [2:0]  st;
    logic [3:0]  acc;
    logic [1:0]  wr;
    logic [31:0] base;
    logic [31:0] lim;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{16'h0008, 1'b1, 1'b0, 32'h1234ABCD, 32'h56CF9A78, 3'd0, 4'd2, 2'd0, 32'h56781234, 32'hFABCDFFF},
    '{16'h0013, 1'b1, 1'b1, 32'h00000FFF, 32'h0040F200, 3'd0, 4'd4, 2'd1, 32'h00000000, 32'h00000FFF},
    '{16'h0018, 1'b1, 1'b1, 32'h0000FFFF, 32'h0040F300, 3'd0, 4'd3, 2'd0, 32'h00000000, 32'h0000FFFF},
    '{16'h0020, 1'b1, 1'b1, 32'h00000000, 32'h00001200, 3'd4, 4'd2, 2'd0, 32'h00000000, 32'h00000000},
    '{16'h0028, 1'b1, 1'b0, 32'h00000000, 32'h00008000, 3'd3, 4'd2, 2'd0, 32'h00000000, 32'h00000000},
    '{16'h0030, 1'b1, 1'b0, 32'h0010BEEF, 32'hDEADEC03, 3'd0, 4'd2, 2'd0, 32'hDE030010, 32'hDBEEFFFF},
    '{16'h0038, 1'b1, 1'b0, 32'h00000000, 32'h00008E20, 3'd3, 4'd2, 2'd0, 32'h00000000, 32'h00000000},
    '{16'h0040, 1'b1, 1'b0, 32'h00000000, 32'h00000000, 3'd2, 4'd0, 2'd0, 32'h00000000, 32'h00000000},
    '{16'h0004, 1'b0, 1'b0, 32'h00000000, 32'h00000000, 3'd1, 4'd0, 2'd0, 32'h00000000, 32'h00000000},
    '{16'h000C, 1'b1, 1'b1, 32'h10000067, 32'h00008900, 3'd0, 4'd2, 2'd0, 32'h00001000, 32'h00000067},
    '{16'h001C, 1'b1, 1'b0, 32'h00000000, 32'h00009200, 3'd0, 4'd2, 2'd0, 32'h00000000, 32'h00000000},
    '{16'h0024, 1'b1, 1'b0, 32'h00000000, 32'h00000000, 3'd2, 4'd0, 2'd0, 32'h00000000, 32'h00000000},
    '{16'h0010, 1'b1, 1'b0, 32'h00000000, 32'h00008700, 3'd0, 4'd2, 2'd0, 32'h00000000, 32'h00000000},
    '{16'h0010, 1'b1, 1'b0, 32'h00000000, 32'h00008800, 3'd3, 4'd2, 2'd0, 32'h00000000, 32'h00000000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] selector = '0;
  logic        mark_acc = 1'b0;
  logic        ldt_ok = 1'b0;
  logic        mem_req, mem_we, done, tbl_local;
  logic [31:0] mem_addr, mem_wdata, d_base, d_limit, g_off;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic [2:0]  status;
  logic [1:0]  rpl, d_dpl;
  logic        d_present, d_codedata, d_dflt, d_gran, d_valid;
  logic [3:0]  d_type;
  logic [15:0] g_sel;
  logic [4:0]  g_cnt;

  logic [31:0] mem [64];
  int          acc_cnt;
  int          wr_cnt;
  logic [31:0] alog [8];
  logic [31:0] last_wdata;
  int          errors = 0;
  int          checks = 0;

  always #(PERIOD/2) clk = ~clk;

  seg_desc_fetch u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .selector(selector), .mark_acc(mark_acc),
    .gdt_base(GBASE), .gdt_limit(GLIM), .ldt_ok(ldt_ok), .ldt_base(LBASE), .ldt_limit(LLIM),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .status(status),
    .rpl(rpl), .tbl_local(tbl_local), .d_present(d_present), .d_dpl(d_dpl),
    .d_codedata(d_codedata), .d_type(d_type), .d_dflt(d_dflt), .d_gran(d_gran),
    .d_base(d_base), .d_limit(d_limit), .d_valid(d_valid), .g_sel(g_sel),
    .g_off(g_off), .g_cnt(g_cnt)
  );

  // one-wait-state memory model; writes are logged, not stored
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      acc_cnt   <= 0;
      wr_cnt    <= 0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[7:2]];
      alog[acc_cnt % 8] <= mem_addr;
      acc_cnt   <= acc_cnt + 1;
      if (mem_we) begin
        wr_cnt     <= wr_cnt + 1;
        last_wdata <= mem_wdata;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 actual=no_done expected=done");
    end
  endtask

  task automatic run(input vec_t v);
    int a0, w0;
    logic [31:0] ea;
    ea = (v.sel[2] ? LBASE : GBASE) + {16'd0, v.sel & 16'hFFF8};
    mem[ea[7:2]]           = v.lo;
    mem[ea[7:2] + 6'd1]    = v.hi;
    a0 = acc_cnt; w0 = wr_cnt;
    selector = v.sel; ldt_ok = v.lok; mark_acc = v.mark; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_done();
    check("R11 status", {29'd0, status}, {29'd0, v.st});
    check("R2 R3 R9 access count", acc_cnt - a0, {28'd0, v.acc});
    check("R10 write count", wr_cnt - w0, {30'd0, v.wr});
    check("R1 rpl", {30'd0, rpl}, {30'd0, v.sel[1:0]});
    check("R1 tbl_local", {31'd0, tbl_local}, {31'd0, v.sel[2]});
    if (v.acc >= 4'd2) begin
      check("R4 low address", alog[a0 % 8], ea);
      check("R4 high address", alog[(a0 + 1) % 8], ea + 32'd4);
      check("R8 valid", {31'd0, d_valid}, {31'd0, v.st != 3'd3});
    end
    if (v.st == 3'd0) begin
      check("R6 base", d_base, v.base);
      check("R6 limit", d_limit, v.lim);
    end
    if (v.wr != 2'd0) check("R10 written word", last_wdata, v.hi | 32'h100);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R11 reset done", {31'd0, done}, 32'd0);
    check("R12 reset mem_req", {31'd0, mem_req}, 32'd0);
    check("R11 reset status", {29'd0, status}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run(VEC[i]);

    // R5 and R7: call gate field decode
    run(VEC[5]);
    check("R5 present", {31'd0, d_present}, 32'd1);
    check("R5 dpl", {30'd0, d_dpl}, 32'd3);
    check("R5 codedata", {31'd0, d_codedata}, 32'd0);
    check("R5 type", {28'd0, d_type}, 32'd12);
    check("R5 gran", {31'd0, d_gran}, 32'd1);
    check("R5 dflt", {31'd0, d_dflt}, 32'd0);
    check("R7 gate selector", {16'd0, g_sel}, 32'h0010);
    check("R7 gate offset", g_off, 32'hDEADBEEF);
    check("R7 gate count", {27'd0, g_cnt}, 32'd3);

    // R5: data segment with size bit set
    run(VEC[1]);
    check("R5 dflt data", {31'd0, d_dflt}, 32'd1);
    check("R5 type data", {28'd0, d_type}, 32'd2);

    // R11: request held through completion, faulting selector accepted in done cycle
    begin
      int a0;
      mem[6'd18] = VEC[0].lo;
      mem[6'd19] = VEC[0].hi;
      selector = 16'h0008; ldt_ok = 1'b1; mark_acc = 1'b0; req = 1'b1;
      @(negedge clk);
      wait_done();
      check("R11 first status", {29'd0, status}, 32'd0);
      a0 = acc_cnt;
      selector = 16'h0048;
      @(negedge clk);
      check("R11 back-to-back done", {31'd0, done}, 32'd1);
      check("R3 back-to-back status", {29'd0, status}, 32'd2);
      req = 1'b0;
      @(negedge clk);
      check("R11 single pulse", {31'd0, done}, 32'd0);
      check("R3 no bus activity", acc_cnt - a0, 32'd0);
      check("R6 fields kept", d_base, 32'h56781234);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule